// File: doc/BRIEF.md
# Error Location Logger with Block Retirement

This block runs on the host side of a flash memory that has error correction built in. Each finished read reports a block address, a two-bit status code from the memory's ECC logic, and the level of the memory's error output pin. The logger keeps an error count for each block. It compares each new count with a threshold that the host programs at runtime. When a count rises above that threshold, the block is marked as retired in a bitmap. Blocks that keep needing single-bit correction are weak cells, and the bitmap lets the system stop using them before they fail.

An uncorrectable event retires its block at once, whatever the count is. The host chooses whether the error pin signals corrected or uncorrectable errors. A status code and a pin report for the same read are counted as one event. Counts stop at their maximum and do not wrap. Counts and retirement flags are cleared only by an explicit clear command or by reset. A one-cycle interrupt fires whenever a block goes from active to retired. Each count can be read through a small register port.

Top module: `err_loc_logger`

## Requirements
- R1: While `rst` is high, all counts are cleared, `retired` is all zero, `irq` is low and `reg_data` is zero. All of these are still true in the cycle after `rst` goes low.
- R2: When `rd_done` is high and an event occurs, the count of block `rd_block` goes up by exactly one. An event is a status of 2'b01 (corrected), a status of 2'b10 (uncorrectable), or `err_pin` high. A read that has both a status event and `err_pin` high adds one, not two.
- R3: A read with status 2'b00 (clean) or 2'b11 (reserved) and `err_pin` low changes no count and no flag. The same holds for any input while `rd_done` is low.
- R4: A count that has reached 2**CNT_W-1 stays at that value on further events.
- R5: After an update, if the block's new count is greater than `thresh`, the block's `retired` bit is set. The value of `thresh` used is the one present in the cycle of the update.
- R6: An uncorrectable event sets the block's `retired` bit in the same update, whatever the count and threshold are. An uncorrectable event is a status of 2'b10, or `err_pin` high while `pin_fatal` is 1.
- R7: `irq` is high for exactly the one cycle after an update that moves a block from not retired to retired. It stays low for events on blocks that are already retired.
- R8: A `retired` bit stays set until `clr`. A `clr` pulse zeroes all counts and flags, and it takes priority over a read in the same cycle.
- R9: `reg_data` is valid one clock after `reg_addr` is presented. It shows the count of that block as it stood before that clock edge.
- R10: When `pin_fatal` is 0, `err_pin` on its own counts as a corrected event. It adds to the count but does not retire the block by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_done | input | 1 | Strobe: a read has completed |
| rd_block | input | BLK_W | Block address of the completed read |
| rd_status | input | 2 | ECC status: 00 clean, 01 corrected, 10 uncorrectable, 11 reserved |
| err_pin | input | 1 | Level of the memory's error pin for this read |
| pin_fatal | input | 1 | 1: pin means uncorrectable; 0: pin means corrected |
| thresh | input | CNT_W | Retirement threshold (retire when count > thresh) |
| clr | input | 1 | Clear all counts and retirement flags |
| reg_addr | input | BLK_W | Block whose count is to be read |
| reg_data | output | CNT_W | Registered count of block `reg_addr` |
| retired | output | NUM_BLOCKS | Retirement bitmap, one bit per block |
| irq | output | 1 | One-cycle pulse when a block becomes retired |

## Verification
The assertions check, on every cycle, that each count either holds or steps up by one, that a saturated count stays saturated, and that retirement flags stay set until a clear. They also check that an interrupt always goes with a newly set flag, and that an uncorrectable read always leaves its block retired. Other behaviour can only be shown by the bench's scenarios, because it depends on the reference model. This covers threshold crossings under a threshold that changes at runtime, a status and pin reported together being counted once, the effect of the pin-mode select, a clear beating a read in the same cycle, and the values and timing of the readout port.

// File: rtl/elog_pkg.sv
package elog_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_UNFIX = 2'b10,
    ST_RSVD  = 2'b11
  } rd_status_e;

  typedef struct packed {
    logic hit;    // read produced an ECC event of any kind
    logic fatal;  // event is uncorrectable
  } evt_t;
endpackage

// File: rtl/elog_classify.sv
module elog_classify
  import elog_pkg::*;
(
  input  logic       rd_done,
  input  logic [1:0] rd_status,
  input  logic       err_pin,
  input  logic       pin_fatal,
  output evt_t       evt
);
  rd_status_e st;
  logic       st_fixed, st_unfix;

  always_comb begin
    st       = rd_status_e'(rd_status);
    st_fixed = (st == ST_FIXED);
    st_unfix = (st == ST_UNFIX);
    // status and pin may describe the same read: merge into one event
    evt.hit   = rd_done && (st_fixed || st_unfix || err_pin);
    evt.fatal = rd_done && (st_unfix || (err_pin && pin_fatal));
  end
endmodule

// File: rtl/elog_count_bank.sv
module elog_count_bank
  import elog_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int CNT_W      = 4,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  evt_t             evt,
  input  logic [BLK_W-1:0] blk,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt_q [NUM_BLOCKS],
  output logic [NUM_BLOCKS-1:0] ret_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_BLOCKS-1:0] newly_ret;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    logic             sel;
    logic [CNT_W-1:0] nxt;
    logic             ret_cond;

    always_comb begin
      sel          = evt.hit && (blk == BLK_W'(i));
      nxt          = (cnt_q[i] == CNT_MAX) ? CNT_MAX : cnt_q[i] + 1'b1;
      ret_cond     = evt.fatal || (nxt > thresh);
      newly_ret[i] = sel && ret_cond && !ret_q[i] && !clr;
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q[i] <= '0;
        ret_q[i] <= 1'b0;
      end else if (sel) begin
        cnt_q[i] <= nxt;
        if (ret_cond) ret_q[i] <= 1'b1;
      end
    end

    // R2: a count holds or steps by one between clears
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(clr) |-> (cnt_q[i] == $past(cnt_q[i]) ||
                       cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1)));
    // R4: a saturated count never wraps
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(cnt_q[i]) == CNT_MAX && !$past(clr)) |-> cnt_q[i] == CNT_MAX);
    // R8: retirement is sticky until clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(ret_q[i]) && !$past(clr)) |-> ret_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |newly_ret;
  end

  // R7: every interrupt pulse goes with a newly set retirement flag
  p_irq_new_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($countones(ret_q & ~$past(ret_q)) >= 1));
endmodule

// File: rtl/err_loc_logger.sv
module err_loc_logger
  import elog_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int CNT_W      = 4,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_done,
  input  logic [BLK_W-1:0]      rd_block,
  input  logic [1:0]            rd_status,
  input  logic                  err_pin,
  input  logic                  pin_fatal,
  input  logic [CNT_W-1:0]      thresh,
  input  logic                  clr,
  input  logic [BLK_W-1:0]      reg_addr,
  output logic [CNT_W-1:0]      reg_data,
  output logic [NUM_BLOCKS-1:0] retired,
  output logic                  irq
);
  evt_t             evt;
  logic [CNT_W-1:0] cnt [NUM_BLOCKS];

  elog_classify u_cls (
    .rd_done   (rd_done),
    .rd_status (rd_status),
    .err_pin   (err_pin),
    .pin_fatal (pin_fatal),
    .evt       (evt)
  );

  elog_count_bank #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .evt    (evt),
    .blk    (rd_block),
    .thresh (thresh),
    .cnt_q  (cnt),
    .ret_q  (retired),
    .irq_q  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_data <= '0;
    else     reg_data <= cnt[reg_addr];
  end

  // R6: an uncorrectable read leaves its block retired
  p_fatal_retires_r6: assert property (@(posedge clk) disable iff (rst)
    (evt.fatal && !clr) |=> retired[$past(rd_block)]);
  // R1: reset leaves no interrupt behind
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && retired == '0));
endmodule

// File: tb/err_loc_logger_test.sv
module err_loc_logger_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int CW = 4;
  localparam int BW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic rd_done = 0, err_pin = 0, pin_fatal = 0, clr = 0;
  logic [BW-1:0] rd_block = 0, reg_addr = 0;
  logic [1:0] rd_status = 0;
  logic [CW-1:0] thresh = 0, reg_data;
  logic [NB-1:0] retired;
  logic irq;

  int checks = 0, failures = 0;
  int m_cnt [NB];
  logic [NB-1:0] m_ret;
  logic m_irq;
  int m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_loc_logger #(.NUM_BLOCKS(NB), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .rd_done(rd_done), .rd_block(rd_block),
    .rd_status(rd_status), .err_pin(err_pin), .pin_fatal(pin_fatal),
    .thresh(thresh), .clr(clr), .reg_addr(reg_addr), .reg_data(reg_data),
    .retired(retired), .irq(irq));

  function automatic bit is_hit(logic d, logic [1:0] s, logic p);
    return d && (s == 2'b01 || s == 2'b10 || p);
  endfunction
  function automatic bit is_fatal(logic d, logic [1:0] s, logic p, logic pf);
    return d && (s == 2'b10 || (p && pf));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs already driven; update model, then compare at negedge
  task automatic cyc(string req);
    int nc;
    m_rd = rst ? 0 : m_cnt[reg_addr];
    m_irq = 0;
    if (rst || clr) begin
      for (int i = 0; i < NB; i++) m_cnt[i] = 0;
      m_ret = '0;
    end else if (is_hit(rd_done, rd_status, err_pin)) begin
      nc = (m_cnt[rd_block] == CMAX) ? CMAX : m_cnt[rd_block] + 1;
      m_cnt[rd_block] = nc;
      if (is_fatal(rd_done, rd_status, err_pin, pin_fatal) || nc > int'(thresh)) begin
        if (!m_ret[rd_block]) m_irq = 1;
        m_ret[rd_block] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({req, " retired"}, int'(retired), int'(m_ret));
    check({req, " irq"}, int'(irq), int'(m_irq));
    check({req, " reg_data"}, int'(reg_data), m_rd);
  endtask

  task automatic rd(int b, int s, bit p, string req);
    rd_done = 1; rd_block = BW'(b); rd_status = 2'(s); err_pin = p;
    cyc(req);
    rd_done = 0; err_pin = 0; rd_status = 0;
  endtask

  task automatic peek(int b, int exp, string req);
    reg_addr = BW'(b);
    cyc(req);
    check({req, " count"}, int'(reg_data), exp);
  endtask

  initial begin
    int seed = 0;
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ret = '0;
    for (int i = 0; i < NB; i++) m_cnt[i] = 0;
    @(negedge clk);
    rd_done = 1; rd_status = 2'b10; // R1: stimulus under reset has no effect
    cyc("R1");
    cyc("R1");
    rd_done = 0; rd_status = 0;
    rst = 0;
    cyc("R1");
    check("R1 irq low", int'(irq), 0);

    thresh = 4'd15; pin_fatal = 0;
    // R3: clean and reserved status, and no strobe, change nothing
    rd(2, 0, 0, "R3");
    rd(2, 3, 0, "R3");
    rd_block = 2; rd_status = 2'b10; cyc("R3"); rd_status = 0;
    peek(2, 0, "R3");
    // R2: status and pin together count once
    rd(2, 1, 1, "R2");
    peek(2, 1, "R2");
    // R10: pin alone in corrected mode counts but does not retire
    rd(2, 0, 1, "R10");
    peek(2, 2, "R10");
    check("R10 not retired", int'(retired[2]), 0);
    // R4: saturation
    for (int k = 0; k < 20; k++) rd(3, 1, 0, "R4");
    peek(3, CMAX, "R4");
    check("R4 no retire at max thresh", int'(retired[3]), 0);
    // R6: uncorrectable status retires immediately
    rd(5, 2, 0, "R6");
    check("R6 status retire", int'(retired[5]), 1);
    pin_fatal = 1;
    rd(6, 0, 1, "R6");
    check("R6 pin retire", int'(retired[6]), 1);
    // R7: no second pulse on already retired block
    rd(6, 2, 0, "R7");
    check("R7 no repeat irq", int'(irq), 0);
    pin_fatal = 0;
    // R5: threshold crossing at runtime value
    thresh = 4'd2;
    rd(8, 1, 0, "R5"); rd(8, 1, 0, "R5");
    check("R5 at thresh", int'(retired[8]), 0);
    rd(8, 1, 0, "R5");
    check("R5 above thresh", int'(retired[8]), 1);
    check("R7 pulse", int'(irq), 1);
    // R8: clear beats a coincident read
    clr = 1; rd(9, 2, 0, "R8"); clr = 0;
    check("R8 cleared", int'(retired), 0);
    peek(9, 0, "R8");
    peek(3, 0, "R8");
    // R9: readout timing under random traffic
    for (int n = 0; n < 4000; n++) begin
      rd_done   = ($urandom_range(9) < 7);
      rd_block  = BW'($urandom_range(NB-1));
      rd_status = 2'($urandom_range(3));
      err_pin   = ($urandom_range(3) == 0);
      pin_fatal = ($urandom_range(7) == 0);
      clr       = ($urandom_range(299) == 0);
      reg_addr  = BW'($urandom_range(NB-1));
      if ($urandom_range(99) == 0) thresh = CW'($urandom_range(CMAX));
      if (rd_status == 2'b10 && $urandom_range(3) != 0) rd_status = 2'b01;
      cyc("R9 random");
    end
    rd_done = 0; clr = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule